// File: doc/BRIEF.md
# PIP Window Grey Fill Inserter

This block sits at the end of the display path of one picture-in-picture window. It takes the pixel stream fetched from picture memory, together with the window-relative line number, and replaces pixels with a flat 30% grey in two cases. The first case is a picture that has fewer lines than the window, such as a 60 Hz picture in a window sized for 50 Hz. The missing lines then become grey bars, split between the top and the bottom of the window. The second case is a layout change that the channel has not yet caught up with. Until a full acquisition field has been written after the change, the whole window is painted grey.

A bar-disable control removes the bars. The picture then starts at the first window line. A fill-disable control keeps the stored memory content visible across layout changes, so earlier data can be reused. The block derives the channel-updated state itself from a layout-change strobe and from the acquisition field start and end pulses. It takes the control inputs and line counts only at the start of a display field, so a window never changes its geometry partway through a field. The output is registered, with one cycle of latency. For the memory side, the block also gives the picture line that belongs to each window line.

Top module: `pip_grey_fill`

## Requirements
- R1: While `rst_ni` is low, `y_o`, `c_o`, `pix_valid_o` and `pic_line_o` are all 0.
- R2: Every output follows its input with exactly one clock of latency. `pix_valid_o` equals `pix_valid_i` from the previous cycle. A pixel that is not greyed appears on `y_o`/`c_o` unchanged.
- R3: The missing-line count is `win_lines - src_lines`. The top bar is the missing count divided by two, rounded down. The bottom bar takes the remaining lines, so an odd count puts the extra line at the bottom. With bars enabled, window lines inside either bar are output grey.
- R4: Grey is luma 82 on `y_o` and chroma 128 on `c_o`.
- R5: With the sampled bar-disable bit at 1, no bar grey is inserted and `pic_line_o` equals the window line.
- R6: With bars enabled and `win_lines > src_lines`, `pic_line_o` is the window line minus the top-bar height for lines at or below the top bar, and 0 for lines inside the top bar.
- R7: A `mode_change_i` pulse clears the channel-updated state. While that state is clear and the sampled fill-disable bit is 0, every output pixel is grey.
- R8: The updated state is set by an `acq_field_end_i` pulse only when an `acq_field_start_i` pulse came in an earlier cycle after the last layout change. Reset counts as a layout change. An end pulse with no earlier start leaves the state clear. If a start and a change arrive in the same cycle, the change wins.
- R9: With the sampled fill-disable bit at 1, pixels are never filled grey, whatever the updated state.
- R10: `bar_off_i`, `fill_off_i`, `src_lines_i` and `win_lines_i` take effect only on the clock edge that samples `disp_field_start_i` high. Changes at any other time have no effect on the output.
- R11: When `win_lines <= src_lines`, no bars are inserted and `pic_line_o` equals the window line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disp_field_start_i | input | 1 | Display field start pulse; samples the controls |
| mode_change_i | input | 1 | Layout-change strobe |
| acq_field_start_i | input | 1 | Acquisition field start pulse |
| acq_field_end_i | input | 1 | Acquisition field end pulse |
| bar_off_i | input | 1 | 1 = omit bars and shift the picture up |
| fill_off_i | input | 1 | 1 = always show memory content |
| src_lines_i | input | LINE_W | Lines in the source picture |
| win_lines_i | input | LINE_W | Lines in the window |
| pix_valid_i | input | 1 | Input pixel valid |
| line_i | input | LINE_W | Window-relative line of the input pixel |
| y_i | input | DATA_W | Input luma |
| c_i | input | DATA_W | Input multiplexed chroma |
| pix_valid_o | output | 1 | Output pixel valid |
| y_o | output | DATA_W | Output luma |
| c_o | output | DATA_W | Output chroma |
| pic_line_o | output | LINE_W | Picture line for this window line |

## Verification
The bench uses an odd missing-line count to catch a design that rounds the split the wrong way. Such a design would grey one line too many at the top and shift `pic_line_o` by one. It sends an acquisition end pulse with no start before it after a layout change. A design that sets the updated state on any end pulse would drop the grey fill one field too early. It changes the controls in the middle of a field and checks that the bars stay as they were until the next display field start. It also covers windows smaller than or equal to the picture, where a wrapped subtraction would produce huge bars.

// File: rtl/pip_fill_pkg.sv
package pip_fill_pkg;
  localparam int unsigned LINE_W_DEF = 10;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned GREY_Y_DEF = 82;
  localparam int unsigned GREY_C_DEF = 128;

  typedef enum logic [1:0] {
    PIX_SRC_MEM  = 2'd0,
    PIX_SRC_BAR  = 2'd1,
    PIX_SRC_FILL = 2'd2
  } pix_src_e;
endpackage

// File: rtl/pip_fill_ctrl_reg.sv
module pip_fill_ctrl_reg #(
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              bar_off_i,
  input  logic              fill_off_i,
  input  logic [LINE_W-1:0] src_lines_i,
  input  logic [LINE_W-1:0] win_lines_i,
  output logic              bar_off_o,
  output logic              fill_off_o,
  output logic [LINE_W-1:0] src_lines_o,
  output logic [LINE_W-1:0] win_lines_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_off_o   <= 1'b0;
      fill_off_o  <= 1'b0;
      src_lines_o <= '0;
      win_lines_o <= '0;
    end else if (sample_i) begin
      bar_off_o   <= bar_off_i;
      fill_off_o  <= fill_off_i;
      src_lines_o <= src_lines_i;
      win_lines_o <= win_lines_i;
    end
  end
endmodule

// File: rtl/pip_update_track.sv
module pip_update_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_change_i,
  input  logic acq_start_i,
  input  logic acq_end_i,
  output logic updated_o
);
  logic seen_start_q;

  // reset behaves as a layout change: wait for one full acquisition field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_start_q <= 1'b0;
      updated_o    <= 1'b0;
    end else if (mode_change_i) begin
      seen_start_q <= 1'b0;
      updated_o    <= 1'b0;
    end else begin
      if (acq_start_i) seen_start_q <= 1'b1;
      if (acq_end_i && seen_start_q) updated_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pip_bar_calc.sv
module pip_bar_calc #(
  parameter int unsigned LINE_W = 10
) (
  input  logic              bar_off_i,
  input  logic [LINE_W-1:0] src_lines_i,
  input  logic [LINE_W-1:0] win_lines_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              in_bar_o,
  output logic [LINE_W-1:0] pic_line_o
);
  logic              bars_on;
  logic [LINE_W-1:0] missing;
  logic [LINE_W-1:0] top_h;
  logic [LINE_W:0]   pic_end;

  always_comb begin
    bars_on = !bar_off_i && (win_lines_i > src_lines_i);
    missing = bars_on ? (win_lines_i - src_lines_i) : '0;
    top_h   = missing >> 1;  // odd extra line lands in the bottom bar
    pic_end = {1'b0, top_h} + {1'b0, src_lines_i};
    if (!bars_on) begin
      in_bar_o   = 1'b0;
      pic_line_o = line_i;
    end else if (line_i < top_h) begin
      in_bar_o   = 1'b1;
      pic_line_o = '0;
    end else begin
      in_bar_o   = ({1'b0, line_i} >= pic_end);
      pic_line_o = line_i - top_h;
    end
  end
endmodule

// File: rtl/pip_grey_fill.sv
module pip_grey_fill
  import pip_fill_pkg::*;
#(
  parameter int unsigned LINE_W = LINE_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned GREY_Y = GREY_Y_DEF,
  parameter int unsigned GREY_C = GREY_C_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_field_start_i,
  input  logic              mode_change_i,
  input  logic              acq_field_start_i,
  input  logic              acq_field_end_i,
  input  logic              bar_off_i,
  input  logic              fill_off_i,
  input  logic [LINE_W-1:0] src_lines_i,
  input  logic [LINE_W-1:0] win_lines_i,
  input  logic              pix_valid_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] c_i,
  output logic              pix_valid_o,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] c_o,
  output logic [LINE_W-1:0] pic_line_o
);
  localparam logic [DATA_W-1:0] GreyY = DATA_W'(GREY_Y);
  localparam logic [DATA_W-1:0] GreyC = DATA_W'(GREY_C);

  logic              bar_off_q, fill_off_q, upd_q, in_bar;
  logic [LINE_W-1:0] src_q, win_q, pic_line_d;
  pix_src_e          pix_src;

  pip_fill_ctrl_reg #(.LINE_W(LINE_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_i    (disp_field_start_i),
    .bar_off_i   (bar_off_i),
    .fill_off_i  (fill_off_i),
    .src_lines_i (src_lines_i),
    .win_lines_i (win_lines_i),
    .bar_off_o   (bar_off_q),
    .fill_off_o  (fill_off_q),
    .src_lines_o (src_q),
    .win_lines_o (win_q)
  );

  pip_update_track u_upd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_change_i (mode_change_i),
    .acq_start_i   (acq_field_start_i),
    .acq_end_i     (acq_field_end_i),
    .updated_o     (upd_q)
  );

  pip_bar_calc #(.LINE_W(LINE_W)) u_bar (
    .bar_off_i   (bar_off_q),
    .src_lines_i (src_q),
    .win_lines_i (win_q),
    .line_i      (line_i),
    .in_bar_o    (in_bar),
    .pic_line_o  (pic_line_d)
  );

  always_comb begin
    if (!upd_q && !fill_off_q) pix_src = PIX_SRC_FILL;
    else if (in_bar)           pix_src = PIX_SRC_BAR;
    else                       pix_src = PIX_SRC_MEM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      y_o         <= '0;
      c_o         <= '0;
      pic_line_o  <= '0;
    end else begin
      pix_valid_o <= pix_valid_i;
      pic_line_o  <= pic_line_d;
      if (pix_src == PIX_SRC_MEM) begin
        y_o <= y_i;
        c_o <= c_i;
      end else begin
        y_o <= GreyY;
        c_o <= GreyC;
      end
    end
  end
endmodule

// File: rtl/pip_grey_fill_chk.sv
module pip_grey_fill_chk #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GREY_Y = 82,
  parameter int unsigned GREY_C = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              disp_field_start_i,
  input logic              mode_change_i,
  input logic              acq_field_end_i,
  input logic              pix_valid_i,
  input logic              pix_valid_o,
  input logic [DATA_W-1:0] y_o,
  input logic [DATA_W-1:0] c_o,
  input logic              upd_q,
  input logic              fill_off_q,
  input logic              bar_off_q,
  input logic [LINE_W-1:0] src_q,
  input logic [LINE_W-1:0] win_q
);
  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pix_valid_o == $past(pix_valid_i));

  assert_change_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_change_i |=> !upd_q);

  assert_update_on_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(upd_q) |-> $past(acq_field_end_i));

  assert_fill_grey_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_q && !fill_off_q) |=> (y_o == DATA_W'(GREY_Y) && c_o == DATA_W'(GREY_C)));

  assert_ctrl_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_field_start_i |=> ($stable(bar_off_q) && $stable(fill_off_q)
                             && $stable(src_q) && $stable(win_q)));
endmodule

bind pip_grey_fill pip_grey_fill_chk #(
  .LINE_W(LINE_W), .DATA_W(DATA_W), .GREY_Y(GREY_Y), .GREY_C(GREY_C)
) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .disp_field_start_i (disp_field_start_i),
  .mode_change_i      (mode_change_i),
  .acq_field_end_i    (acq_field_end_i),
  .pix_valid_i        (pix_valid_i),
  .pix_valid_o        (pix_valid_o),
  .y_o                (y_o),
  .c_o                (c_o),
  .upd_q              (upd_q),
  .fill_off_q         (fill_off_q),
  .bar_off_q          (bar_off_q),
  .src_q              (src_q),
  .win_q              (win_q)
);

// File: tb/pip_grey_fill_tb_top.sv
module pip_grey_fill_tb_top;
  localparam int LW = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ds = 0, mc = 0, as = 0, ae = 0, bo = 0, fo = 0, vi = 0;
  logic [LW-1:0] src = '0, win = '0, ln = '0;
  logic [DW-1:0] yi = '0, ci = '0;
  logic          vo;
  logic [DW-1:0] yo, co;
  logic [LW-1:0] plo;

  always #2ns clk = ~clk;

  pip_grey_fill dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_field_start_i(ds), .mode_change_i(mc),
    .acq_field_start_i(as), .acq_field_end_i(ae),
    .bar_off_i(bo), .fill_off_i(fo),
    .src_lines_i(src), .win_lines_i(win),
    .pix_valid_i(vi), .line_i(ln), .y_i(yi), .c_i(ci),
    .pix_valid_o(vo), .y_o(yo), .c_o(co), .pic_line_o(plo)
  );

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_upd = 0, m_seen = 0, m_bo = 0, m_fo = 0, m_src = 0, m_win = 0;
  int e_v = 0, e_y = 0, e_c = 0, e_pl = 0;

  task automatic compare();
    n_tests++;
    if (vo !== e_v[0] || yo !== e_y[DW-1:0] || co !== e_c[DW-1:0] || plo !== e_pl[LW-1:0]) begin
      n_fail++;
      $display("FAIL %s: got v=%0d y=%0d c=%0d pl=%0d exp v=%0d y=%0d c=%0d pl=%0d",
               cur_req, vo, yo, co, plo, e_v, e_y, e_c, e_pl);
    end
  endtask

  // drive inputs, predict next output, advance model as of the coming edge
  task automatic apply(input int v, input int l, input int y, input int c,
                       input int d_s, input int m_c, input int a_s, input int a_e);
    int top, miss, grey;
    vi = v[0]; ln = l[LW-1:0]; yi = y[DW-1:0]; ci = c[DW-1:0];
    ds = d_s[0]; mc = m_c[0]; as = a_s[0]; ae = a_e[0];
    miss = (m_bo == 0 && m_win > m_src) ? m_win - m_src : 0;
    top  = miss / 2;
    grey = 0;
    if (m_upd == 0 && m_fo == 0) grey = 1;                                // R7
    if (miss > 0 && (l < top || l >= top + m_src)) grey = 1;              // R3
    e_v  = v;
    e_pl = (miss == 0) ? l : (l < top ? 0 : l - top);                     // R5 R6 R11
    e_y  = grey ? 82 : y;                                                 // R4
    e_c  = grey ? 128 : c;
    if (d_s != 0) begin
      m_bo = bo; m_fo = fo; m_src = src; m_win = win;                     // R10
    end
    if (m_c != 0) begin
      m_upd = 0; m_seen = 0;
    end else begin
      if (a_e != 0 && m_seen != 0) m_upd = 1;                             // R8
      if (a_s != 0) m_seen = 1;
    end
  endtask

  task automatic step(input int v, input int l, input int y, input int c,
                      input int d_s, input int m_c, input int a_s, input int a_e);
    @(negedge clk);
    compare();
    apply(v, l, y, c, d_s, m_c, a_s, a_e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic field_start();
    step(0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic acq_field();
    step(0, 0, 0, 0, 0, 0, 1, 0);
    idle(2);
    step(0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic stream(input int lines);
    for (int l = 0; l < lines; l++) step(1, l, 16 + 7 * l, 60 + 3 * l, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    n_tests++;
    if (vo !== 1'b0 || yo !== '0 || co !== '0 || plo !== '0) begin
      n_fail++;
      $display("FAIL R1: got v=%0d y=%0d c=%0d pl=%0d exp 0 0 0 0", vo, yo, co, plo);
    end
    rst_n = 1'b1;
    apply(0, 0, 0, 0, 0, 0, 0, 0);

    // R7 R8: after reset the window is filled until a full acquisition field
    cur_req = "R7";
    src = 7; win = 12; bo = 0; fo = 0;
    field_start();
    stream(12);
    cur_req = "R8";
    acq_field();
    // R3 R6: odd missing count 5 -> top 2, bottom 3; R2 latency and passthrough
    cur_req = "R3/R6/R2";
    stream(14);

    // R8: end pulse without a preceding start keeps the fill
    cur_req = "R8";
    step(0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    stream(12);
    step(0, 0, 0, 0, 0, 1, 1, 0);   // start coinciding with change is lost
    step(0, 0, 0, 0, 0, 0, 0, 1);
    stream(4);
    acq_field();
    stream(4);

    // R10: mid-field control change has no effect
    cur_req = "R10";
    bo = 1; src = 3; win = 20;
    stream(12);
    // R5: bars omitted, picture shifted to the top
    cur_req = "R5";
    field_start();
    stream(24);

    // R9: fill disabled keeps memory content after a change
    cur_req = "R9";
    bo = 0; fo = 1; src = 7; win = 12;
    field_start();
    step(0, 0, 0, 0, 0, 1, 0, 0);
    stream(12);

    // R11: window smaller than and equal to picture
    cur_req = "R11";
    fo = 0; src = 8; win = 6;
    field_start();
    acq_field();
    stream(8);
    src = 6; win = 6;
    field_start();
    stream(8);

    // R3: even missing count 4 -> top 2, bottom 2
    cur_req = "R3";
    src = 6; win = 10;
    field_start();
    stream(12);

    // R7: change strobe with fill enabled brings the grey back
    cur_req = "R7";
    step(0, 0, 0, 0, 0, 1, 0, 0);
    stream(6);
    idle(1);
    @(negedge clk);
    compare();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule